// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable total ratio of M·N + A. The base modulus M is 64 or 128. A modelled dual-modulus prescaler divides by M or M+1. A swallow counter steers it to M+1 for the first A prescaler cycles of each period. A main counter closes the period after N prescaler cycles. Each completed period produces one output pulse, exactly one input clock wide.

The ratio inputs are read only at period boundaries, so software may rewrite them at any time without corrupting the period in progress. A counter-clear input restarts the division at once, using the values presented on the inputs. An enable input freezes all counting, for power saving. A sticky flag reports any ratio loaded outside the legal range.

Top module: `swallow_divider`

## Requirements
- R1: With `mod_sel` = 0 (M = 64), `div_pulse` rises once every 64·N + A input cycles. Examples: N=3 A=0 gives 192, N=3 A=2 gives 194, N=5 A=4 gives 324, N=10 A=9 gives 649.
- R2: With `mod_sel` = 1 (M = 128), the period is 128·N + A input cycles. Examples: N=3 A=2 gives 386, N=4 A=0 gives 512.
- R3: `div_pulse` is high for exactly one clock cycle per period.
- R4: Changes to `n_val`, `a_val` and `mod_sel` during a period leave that period's length unchanged. They take effect from the next period.
- R5: Within a period, the first A prescaler cycles last M+1 input cycles and the remaining N−A last M. The extreme A = 127 with N = 128 and M = 64 gives a period of 8319.
- R6: While `en` is low, the counters hold and `div_pulse` stays low. Each disabled cycle lengthens the current period by one input cycle.
- R7: A cycle with `cnt_clr` high reloads the counters from the inputs and forces `div_pulse` low. The next pulse is high in the cycle after the (M·N + A)-th enabled clock edge that follows the clear edge.
- R8: At every load (the end of a period, or a clear), `cfg_err` becomes 1 if `n_val` < 3 or `a_val` ≥ `n_val`. It then stays at 1 until reset, even after legal values are loaded. A = N−1 is legal and leaves the flag at 0.
- R9: A clock edge with `rst_n` low clears `div_pulse` and `cfg_err` and loads the counters from the inputs. The first pulse is high after the (M·N + A)-th enabled edge following reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable; low freezes all counters (power save) |
| cnt_clr | input | 1 | Synchronous counter clear and reload from inputs |
| mod_sel | input | 1 | Base modulus select: 0 = 64/65, 1 = 128/129 |
| n_val | input | 11 | Main counter ratio N (legal 3..2047) |
| a_val | input | 7 | Swallow count A (legal 0..127, below N) |
| div_pulse | output | 1 | One-cycle pulse at each completed period |
| cfg_err | output | 1 | Sticky flag for an illegal ratio loaded |

## Verification
The single-cycle pulse property and the hold checks assume that the shortest period is at least 64 input cycles and that `en` and `cnt_clr` are driven to known values from time zero. The bench drives every input from the first cycle. It changes inputs only just after a clock edge, and it keeps ratios small enough that the run stays short. Legal-range checking is not assumed by any assertion. The bench deliberately loads N = 2 and A = N to exercise the error flag, and then returns to legal values.

// File: rtl/swdiv_pkg.sv
// Shared constants for the pulse-swallow divider.
// Assumes: main counter wider than swallow counter.
package swdiv_pkg;
    localparam int SWD_NW   = 11;   // main counter width
    localparam int SWD_AW   = 7;    // swallow counter width
    localparam int SWD_M_LO = 64;   // base modulus when select is 0
    localparam int SWD_M_HI = 128;  // base modulus when select is 1
    localparam int SWD_NMIN = 3;    // smallest legal main ratio
endpackage

// File: rtl/swd_prescaler.sv
// Dual-modulus prescaler model: counts input cycles and emits a tick at the end
// of each prescaler cycle, which lasts base or base+1 cycles depending on mod_hi.
// Assumes: mod_hi changes only in the cycle after a tick or a restart.
module swd_prescaler #(
    parameter int M_LO = swdiv_pkg::SWD_M_LO,
    parameter int M_HI = swdiv_pkg::SWD_M_HI,
    localparam int CW  = $clog2(M_HI + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  logic sel_hi,
    input  logic mod_hi,
    output logic tick
);
    logic [CW-1:0] pre_cnt;
    logic [CW-1:0] term;

    // Last count value of the current prescaler cycle.
    always_comb begin
        term = (sel_hi ? CW'(M_HI - 1) : CW'(M_LO - 1)) + CW'(mod_hi);
        tick = en && (pre_cnt == term);
    end

    // Input-cycle counter, wraps at the end of each prescaler cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (restart) pre_cnt <= '0;
        else if (tick)    pre_cnt <= '0;
        else if (en)      pre_cnt <= pre_cnt + CW'(1);
    end

    // R5: modulus control must hold steady inside a prescaler cycle
    a_r5_mod_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && !tick) |=> $stable(mod_hi));
endmodule

// File: rtl/swd_swallow.sv
// Swallow counter: loaded with A at each period start, counts down on prescaler
// ticks, and asks for the +1 modulus while it is non-zero.
// Assumes: load covers both period end and external clear.
module swd_swallow #(
    parameter int AW = swdiv_pkg::SWD_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          tick,
    input  logic [AW-1:0] a_in,
    output logic          mod_hi
);
    logic [AW-1:0] sw_rem;

    // Remaining prescaler cycles that still divide by base+1.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sw_rem <= a_in;
        else if (load)                  sw_rem <= a_in;
        else if (tick && sw_rem != '0)  sw_rem <= sw_rem - AW'(1);
    end

    // Modulus control toward the prescaler.
    always_comb mod_hi = (sw_rem != '0);

    // R5: the +1 request only ends at a prescaler tick or a reload
    a_r5_swallow_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_hi) |-> $past(tick || load));
endmodule

// File: rtl/swd_main.sv
// Main counter: loaded with N at each period start, counts prescaler ticks and
// flags the tick that completes the period.
// Assumes: N below 2 is illegal; such values end the period after one tick.
module swd_main #(
    parameter int NW = swdiv_pkg::SWD_NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          tick,
    input  logic [NW-1:0] n_in,
    output logic          period_end
);
    logic [NW-1:0] main_rem;

    // Final tick of the period.
    always_comb period_end = tick && (main_rem <= NW'(1));

    // Remaining prescaler cycles in this period.
    always_ff @(posedge clk) begin
        if (!rst_n)     main_rem <= n_in;
        else if (load)  main_rem <= n_in;
        else if (tick)  main_rem <= main_rem - NW'(1);
    end
endmodule

// File: rtl/swd_cfg.sv
// Boundary-latched modulus select plus sticky legality flag for loaded ratios.
// Assumes: NW > AW so A can be compared against N after zero extension.
module swd_cfg #(
    parameter int NW   = swdiv_pkg::SWD_NW,
    parameter int AW   = swdiv_pkg::SWD_AW,
    parameter int NMIN = swdiv_pkg::SWD_NMIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sel_in,
    input  logic [NW-1:0] n_in,
    input  logic [AW-1:0] a_in,
    output logic          sel_q,
    output logic          err_q
);
    logic bad_cfg;

    // Illegal ratio: N too small or swallow count not below N.
    always_comb bad_cfg = (n_in < NW'(NMIN)) || ({{(NW-AW){1'b0}}, a_in} >= n_in);

    // Modulus select held for the whole period.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= sel_in;
        else if (load)  sel_q <= sel_in;
    end

    // Sticky error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                err_q <= 1'b0;
        else if (load && bad_cfg)  err_q <= 1'b1;
    end
endmodule

// File: rtl/swallow_divider.sv
// Pulse-swallow divider top: prescaler, swallow and main counters, and config
// latch. Emits one registered pulse per M*N+A enabled input cycles.
// Assumes: inputs synchronous to clk; ratios sampled only at loads.
module swallow_divider #(
    parameter int NW   = swdiv_pkg::SWD_NW,
    parameter int AW   = swdiv_pkg::SWD_AW,
    parameter int M_LO = swdiv_pkg::SWD_M_LO,
    parameter int M_HI = swdiv_pkg::SWD_M_HI
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cnt_clr,
    input  logic          mod_sel,
    input  logic [NW-1:0] n_val,
    input  logic [AW-1:0] a_val,
    output logic          div_pulse,
    output logic          cfg_err
);
    logic tick;
    logic mod_hi;
    logic period_end;
    logic load;
    logic sel_q;

    // Counters reload at a period boundary or on an external clear.
    always_comb load = cnt_clr || period_end;

    swd_prescaler #(.M_LO(M_LO), .M_HI(M_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(cnt_clr),
        .sel_hi(sel_q), .mod_hi(mod_hi), .tick(tick)
    );

    swd_swallow #(.AW(AW)) u_swl (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick),
        .a_in(a_val), .mod_hi(mod_hi)
    );

    swd_main #(.NW(NW)) u_main (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick),
        .n_in(n_val), .period_end(period_end)
    );

    swd_cfg #(.NW(NW), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load), .sel_in(mod_sel),
        .n_in(n_val), .a_in(a_val), .sel_q(sel_q), .err_q(cfg_err)
    );

    // Registered output pulse, one cycle after the completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_pulse <= 1'b0;
        else if (cnt_clr) div_pulse <= 1'b0;
        else              div_pulse <= period_end;
    end

    // R3: pulse never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
    // R6: no pulse follows a disabled cycle
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_clr) |=> !div_pulse);
    // R7: clear suppresses the pulse
    a_r7_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> !div_pulse);
    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: tb/swallow_divider_tb.sv
`timescale 1ns/1ps
module swallow_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        cnt_clr = 1'b0;
    logic        mod_sel = 1'b0;
    logic [10:0] n_val = 11'd3;
    logic [6:0]  a_val = 7'd0;
    logic        div_pulse;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    swallow_divider u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt_clr(cnt_clr), .mod_sel(mod_sel),
        .n_val(n_val), .a_val(a_val), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    // Stimulus table: {mod_sel, N, A}
    localparam logic [18:0] VEC [7] = '{
        {1'b0, 11'd3,   7'd0},
        {1'b0, 11'd3,   7'd2},
        {1'b1, 11'd3,   7'd2},
        {1'b0, 11'd5,   7'd4},
        {1'b1, 11'd4,   7'd0},
        {1'b0, 11'd10,  7'd9},
        {1'b0, 11'd128, 7'd127}
    };

    function automatic int period(input logic s, input int n, input int a);
        return (s ? 128 : 64) * n + a;
    endfunction

    task automatic step();
        @(posedge clk); #1;
        cyc++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count edges until div_pulse is seen high.
    task automatic to_pulse(output int k);
        k = 0;
        do begin
            step();
            k++;
        end while (!div_pulse && k < 40000);
    endtask

    task automatic do_clr();
        cnt_clr = 1'b1;
        step();
        cnt_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5ns * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int k, t;
        // R9: reset state
        repeat (3) step();
        check(div_pulse == 1'b0, "R9 pulse in reset", int'(div_pulse), 0);
        check(cfg_err == 1'b0, "R9 err in reset", int'(cfg_err), 0);
        mod_sel = 1'b0; n_val = 11'd3; a_val = 7'd1;
        step();
        rst_n = 1'b1;
        to_pulse(k);
        check(k == 193, "R9 first pulse after reset", k, 193);

        // Table walk: R1/R2/R5 period, R3 width, R7 clear latency
        foreach (VEC[i]) begin
            {mod_sel, n_val, a_val} = VEC[i];
            t = period(VEC[i][18], int'(VEC[i][17:7]), int'(VEC[i][6:0]));
            do_clr();
            to_pulse(k);
            check(k == t, VEC[i][18] ? "R2/R7 latency" : "R1/R7 latency", k, t);
            step();
            check(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
            to_pulse(k);
            check(k + 1 == t, VEC[i][18] ? "R2 period" : (i == 6 ? "R5 period" : "R1 period"), k + 1, t);
            check(cfg_err == 1'b0, "R8 legal ratio", int'(cfg_err), 0);
        end

        // R4: mid-period change waits for the boundary
        mod_sel = 1'b0; n_val = 11'd3; a_val = 7'd0;
        do_clr();
        to_pulse(k);
        repeat (50) step();
        n_val = 11'd4; a_val = 7'd1;
        to_pulse(k);
        check(k + 50 == 192, "R4 old period kept", k + 50, 192);
        to_pulse(k);
        check(k == 257, "R4 new period used", k, 257);

        // R6: disabled cycles freeze counting
        n_val = 11'd3; a_val = 7'd0;
        do_clr();
        repeat (10) step();
        en = 1'b0;
        t = 0;
        for (int j = 0; j < 20; j++) begin
            step();
            if (div_pulse) t++;
        end
        check(t == 0, "R6 no pulse while disabled", t, 0);
        en = 1'b1;
        to_pulse(k);
        check(k + 30 == 212, "R6 period stretched", k + 30, 212);

        // R8: illegal ratios set the sticky flag
        n_val = 11'd2; a_val = 7'd0;
        do_clr();
        check(cfg_err == 1'b1, "R8 N below 3", int'(cfg_err), 1);
        n_val = 11'd3;
        do_clr();
        check(cfg_err == 1'b1, "R8 sticky", int'(cfg_err), 1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check(cfg_err == 1'b0, "R9 reset clears err", int'(cfg_err), 0);
        n_val = 11'd4; a_val = 7'd4;
        do_clr();
        check(cfg_err == 1'b1, "R8 A not below N", int'(cfg_err), 1);

        finish_run();
    end
endmodule